// File: doc/BRIEF.md
# Scatter-Gather Descriptor Queue

This block sits between software and a storage-card DMA engine. It holds a list of up to sixteen memory segments that together make up one transfer. Software first loads a segment's start address into a staging register. It then writes a command word that gives the segment length, the transfer direction, the byte-swap and endianness options, and whether completion of that segment should interrupt. The command write pushes the staged address and the decoded command into the queue as a single entry.

On the consumer side, the oldest entry is offered to the DMA engine over a valid/ready handshake. Once the engine accepts an entry, the entry stays at the head of the queue until the engine pulses its done input. That pulse removes the entry. If the entry did not suppress its interrupt, the pulse also raises a level interrupt, which stays high until software clears it.

A configuration register shows the occupancy count and holds a low-water threshold and a clear bit. While the clear bit is set, the queue is held empty and refuses new entries. A status register reports the interrupt, a sticky overflow flag for refused pushes, and a live low-water flag.

Top module: `sg_desc_queue`

## Requirements
- R1: After reset, all of the following hold. The occupancy count is 0. The queue is disabled, so configuration bit 16 reads 1. The threshold reads 0. The status register reads 0. `irq` and `dsc_valid` are low.
- R2: The configuration register is at offset 0x00. Writing it with bit 16 = 0 enables the queue. Writing it with bit 16 = 1 empties the queue from the next cycle, drops any accepted entry, and keeps the queue disabled with `dsc_valid` low. Bits 12:8 store the threshold, and it reads back in the same bits.
- R3: A write to offset 0x10 stages a segment address. Address bits 2:0 are ignored: they read back as 0 at offset 0x10 and are presented as 0 on `dsc_addr`.
- R4: A write to offset 0x18 while the queue is enabled and not full appends one entry, made of the staged address and the command fields. The count read in configuration bits 4:0 rises by one on the next cycle.
- R5: Command word fields:
  - bit 62: direction (1 = toward the card)
  - bit 60: interrupt suppress
  - bits 59, 58, 57: 32-bit, 16-bit and 8-bit swap, presented on `dsc_swap[2]`, `dsc_swap[1]` and `dsc_swap[0]`
  - bit 56: endianness
  - bits 55:36: length in 64-bit words minus one
  
  Each field is presented unchanged with its entry.
- R6: A write to offset 0x18 while the queue is full (16 entries) or disabled is dropped. It leaves the count unchanged and sets status bit 1 (overflow), which stays set.
- R7: Entries are offered in the order they were pushed. `dsc_valid` is high when the queue is enabled, non-empty and no entry is accepted. A cycle with `dsc_valid` and `dsc_ready` both high accepts the head, and `dsc_valid` then stays low until that entry completes.
- R8: An `eng_done` pulse while an entry is accepted removes the head and lowers the count by one. An `eng_done` pulse with no accepted entry has no effect.
- R9: Removing an entry whose suppress bit is 0 sets status bit 0 and `irq`. Removing an entry whose suppress bit is 1 leaves them unchanged. Writing 1 to status bit 0 at offset 0x20 clears it, and writing 0 does not. A set in the same cycle as a clear wins.
- R10: Status bit 2 (low water) is 1 exactly when the count is non-zero and at or below the threshold.
- R11: A push and a removal in the same cycle leave the count unchanged.
- R12: Writing 1 to status bit 1 clears the overflow flag, unless a new overflow happens in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register write offset |
| reg_wdata | input | 64 | Register write data |
| reg_raddr | input | 8 | Register read offset |
| reg_rdata | output | 64 | Read data for `reg_raddr` (combinational) |
| dsc_valid | output | 1 | Head entry offered to the engine |
| dsc_ready | input | 1 | Engine accepts the offered entry |
| dsc_addr | output | 64 | Head entry segment address |
| dsc_len | output | 20 | Head entry length in 64-bit words minus one |
| dsc_to_card | output | 1 | Head entry direction (1 = toward card) |
| dsc_no_irq | output | 1 | Head entry interrupt suppress |
| dsc_swap | output | 3 | Head entry swaps {32, 16, 8} |
| dsc_endian | output | 1 | Head entry endianness select |
| eng_done | input | 1 | Engine finished the accepted entry |
| irq | output | 1 | Completion interrupt (level) |

## Verification
The assertions place no limit on the inputs. Stray `eng_done` pulses, pushes into a full or disabled queue, and clear writes that land while an entry is accepted all have defined outcomes, and the properties are written to hold across them. The assertions do take for granted that at most one register write arrives per cycle and that command bits outside the defined fields carry no meaning. The stimulus keeps to this by driving a single write port. It mixes directed sequences for the full, empty, clear and simultaneous push-and-remove cases with a long random phase. That phase draws offsets, data, ready and done freely, so refused pushes and ignored done pulses occur often.

// File: rtl/sgq_pkg.sv
// Package: shared offsets, bit positions and the per-entry command record
// for the scatter-gather descriptor queue. Assumes a 64-bit register word.
package sgq_pkg;

    localparam int LEN_W = 20;
    localparam int THR_W = 5;

    localparam logic [7:0] OFS_CFG   = 8'h00;
    localparam logic [7:0] OFS_STAGE = 8'h10;
    localparam logic [7:0] OFS_CMD   = 8'h18;
    localparam logic [7:0] OFS_STAT  = 8'h20;

    localparam int CFG_CLR_BIT  = 16;
    localparam int CFG_THR_LSB  = 8;

    localparam int CMD_DIR_BIT   = 62;
    localparam int CMD_NOIRQ_BIT = 60;
    localparam int CMD_SWAP_LSB  = 57;
    localparam int CMD_END_BIT   = 56;
    localparam int CMD_LEN_LSB   = 36;

    localparam int STAT_IRQ_BIT = 0;
    localparam int STAT_OVF_BIT = 1;
    localparam int STAT_LOW_BIT = 2;

    typedef struct packed {
        logic             to_card;
        logic             no_irq;
        logic [2:0]       swap;
        logic             endian;
        logic [LEN_W-1:0] len;
    } sgq_desc_t;

endpackage

// File: rtl/sgq_fifo.sv
// Module: circular store of segment entries with an occupancy count.
// Assumes the caller never pushes when full nor pops when empty; a flush
// empties it in one cycle and overrides push and pop.
module sgq_fifo
    import sgq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int DW    = 64,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [DW-1:0]    push_addr,
    input  sgq_desc_t        push_desc,
    input  logic             pop,
    output logic [DW-1:0]    head_addr,
    output sgq_desc_t        head_desc,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DW-1:0] mem_addr [DEPTH];
    sgq_desc_t     mem_desc [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    assign full      = (count == CNT_W'(DEPTH));
    assign empty     = (count == '0);
    assign head_addr = mem_addr[rd_ptr];
    assign head_desc = mem_desc[rd_ptr];

    // Store the incoming entry at the write slot.
    always_ff @(posedge clk) begin
        if (push && !flush) begin
            mem_addr[wr_ptr] <= push_addr;
            mem_desc[wr_ptr] <= push_desc;
        end
    end

    // Advance pointers and keep the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= step(wr_ptr);
            if (pop)  rd_ptr <= step(rd_ptr);
            case ({push, pop})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    assert_pop_has_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
    assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        int'(count) <= DEPTH);

endmodule

// File: rtl/sgq_issue.sv
// Module: hands the head entry to the engine and tracks the one entry the
// engine holds. Assumes done pulses outside an accepted entry are noise.
module sgq_issue (
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic enabled,
    input  logic nonempty,
    input  logic ready,
    input  logic done,
    output logic valid,
    output logic pop
);

    logic inflight;

    assign valid = enabled && nonempty && !inflight;
    assign pop   = inflight && done && !flush;

    // Remember that the engine owns the head entry until it reports done.
    always_ff @(posedge clk) begin
        if (!rst_n || flush)        inflight <= 1'b0;
        else if (pop)               inflight <= 1'b0;
        else if (valid && ready)    inflight <= 1'b1;
    end

    assert_offer_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        valid && !ready && !flush |=> valid);
    assert_accept_origin_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(inflight) |-> $past(valid && ready));
    assert_done_releases_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> !inflight);

endmodule

// File: rtl/sgq_status.sv
// Module: completion interrupt, sticky overflow flag and low-water flag.
// Assumes write-one-to-clear strobes and set events may share a cycle;
// set events take priority.
module sgq_status #(
    parameter int CNT_W = 5,
    parameter int THR_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pop_evt,
    input  logic             pop_no_irq,
    input  logic             ovf_evt,
    input  logic             w1c_wr,
    input  logic [1:0]       w1c_bits,
    input  logic [CNT_W-1:0] count,
    input  logic [THR_W-1:0] thr,
    output logic             irq,
    output logic             ovf,
    output logic             low_water
);

    logic irq_set, ovf_clr, irq_clr;

    assign irq_set   = pop_evt && !pop_no_irq;
    assign irq_clr   = w1c_wr && w1c_bits[0];
    assign ovf_clr   = w1c_wr && w1c_bits[1];
    assign low_water = (count != '0) && (int'(count) <= int'(thr));

    // Completion interrupt: set on an unsuppressed removal, cleared by software.
    always_ff @(posedge clk) begin
        if (!rst_n)       irq <= 1'b0;
        else if (irq_set) irq <= 1'b1;
        else if (irq_clr) irq <= 1'b0;
    end

    // Overflow flag: set on a refused push, cleared by software.
    always_ff @(posedge clk) begin
        if (!rst_n)       ovf <= 1'b0;
        else if (ovf_evt) ovf <= 1'b1;
        else if (ovf_clr) ovf <= 1'b0;
    end

    assert_irq_raise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pop_evt && !pop_no_irq |=> irq);
    assert_irq_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !irq_clr |=> irq);
    assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ovf && !ovf_clr |=> ovf);
    assert_ovf_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_clr && !ovf_evt |=> !ovf);

endmodule

// File: rtl/sg_desc_queue.sv
// Module: register front end of the scatter-gather descriptor queue.
// Decodes writes, stages the segment address, gates pushes by the clear bit
// and fullness, and muxes read data. Assumes one register write per cycle.
module sg_desc_queue
    import sgq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int DW    = 64,
    parameter int RA_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wen,
    input  logic [RA_W-1:0]  reg_addr,
    input  logic [DW-1:0]    reg_wdata,
    input  logic [RA_W-1:0]  reg_raddr,
    output logic [DW-1:0]    reg_rdata,
    output logic             dsc_valid,
    input  logic             dsc_ready,
    output logic [DW-1:0]    dsc_addr,
    output logic [LEN_W-1:0] dsc_len,
    output logic             dsc_to_card,
    output logic             dsc_no_irq,
    output logic [2:0]       dsc_swap,
    output logic             dsc_endian,
    input  logic             eng_done,
    output logic             irq
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             clr_q;
    logic [THR_W-1:0] thr_q;
    logic [DW-1:0]    stage_q;
    logic             wr_cfg, wr_stage, wr_cmd, wr_stat;
    logic             flush, push, pop, ovf_evt;
    logic             full, empty, ovf, low_water;
    logic [CNT_W-1:0] count;
    sgq_desc_t        cmd_fields, head_desc;

    assign wr_cfg   = reg_wen && (reg_addr == RA_W'(OFS_CFG));
    assign wr_stage = reg_wen && (reg_addr == RA_W'(OFS_STAGE));
    assign wr_cmd   = reg_wen && (reg_addr == RA_W'(OFS_CMD));
    assign wr_stat  = reg_wen && (reg_addr == RA_W'(OFS_STAT));

    assign flush   = clr_q || (wr_cfg && reg_wdata[CFG_CLR_BIT]);
    assign push    = wr_cmd && !clr_q && !full;
    assign ovf_evt = wr_cmd && (clr_q || full);

    // Split the command word into the per-entry record.
    always_comb begin
        cmd_fields.to_card = reg_wdata[CMD_DIR_BIT];
        cmd_fields.no_irq  = reg_wdata[CMD_NOIRQ_BIT];
        cmd_fields.swap    = reg_wdata[CMD_SWAP_LSB +: 3];
        cmd_fields.endian  = reg_wdata[CMD_END_BIT];
        cmd_fields.len     = reg_wdata[CMD_LEN_LSB +: LEN_W];
    end

    // Configuration bits: clear/disable and low-water threshold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clr_q <= 1'b1;
            thr_q <= '0;
        end else if (wr_cfg) begin
            clr_q <= reg_wdata[CFG_CLR_BIT];
            thr_q <= reg_wdata[CFG_THR_LSB +: THR_W];
        end
    end

    // Staged segment address with the low three bits forced to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)        stage_q <= '0;
        else if (wr_stage) stage_q <= reg_wdata & ~DW'(7);
    end

    sgq_fifo #(.DEPTH(DEPTH), .DW(DW)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .push      (push),
        .push_addr (stage_q),
        .push_desc (cmd_fields),
        .pop       (pop),
        .head_addr (dsc_addr),
        .head_desc (head_desc),
        .count     (count),
        .full      (full),
        .empty     (empty)
    );

    sgq_issue u_issue (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .enabled  (!clr_q),
        .nonempty (!empty),
        .ready    (dsc_ready),
        .done     (eng_done),
        .valid    (dsc_valid),
        .pop      (pop)
    );

    sgq_status #(.CNT_W(CNT_W), .THR_W(THR_W)) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .pop_evt    (pop),
        .pop_no_irq (head_desc.no_irq),
        .ovf_evt    (ovf_evt),
        .w1c_wr     (wr_stat),
        .w1c_bits   (reg_wdata[1:0]),
        .count      (count),
        .thr        (thr_q),
        .irq        (irq),
        .ovf        (ovf),
        .low_water  (low_water)
    );

    assign dsc_len     = head_desc.len;
    assign dsc_to_card = head_desc.to_card;
    assign dsc_no_irq  = head_desc.no_irq;
    assign dsc_swap    = head_desc.swap;
    assign dsc_endian  = head_desc.endian;

    // Read data for the selected offset.
    always_comb begin
        reg_rdata = '0;
        case (reg_raddr)
            RA_W'(OFS_CFG): begin
                reg_rdata[CFG_CLR_BIT]             = clr_q;
                reg_rdata[CFG_THR_LSB +: THR_W]    = thr_q;
                reg_rdata[CNT_W-1:0]               = count;
            end
            RA_W'(OFS_STAGE): reg_rdata = stage_q;
            RA_W'(OFS_STAT): begin
                reg_rdata[STAT_IRQ_BIT] = irq;
                reg_rdata[STAT_OVF_BIT] = ovf;
                reg_rdata[STAT_LOW_BIT] = low_water;
            end
            default: reg_rdata = '0;
        endcase
    end

    assert_addr_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dsc_valid |-> dsc_addr[2:0] == 3'b000);
    assert_disabled_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clr_q |-> !dsc_valid);
    assert_count_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !flush |=> (int'(count) - int'($past(count))) inside {-1, 0, 1});

endmodule

// File: tb/sg_desc_queue_bench.sv
// Bench: behavioural queue model compared on every clock, plus directed
// sequences for each requirement and a random phase.
module sg_desc_queue_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wen = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [63:0] reg_wdata = '0;
    logic [7:0]  reg_raddr = '0;
    logic [63:0] reg_rdata;
    logic        dsc_valid;
    logic        dsc_ready = 1'b0;
    logic [63:0] dsc_addr;
    logic [19:0] dsc_len;
    logic        dsc_to_card, dsc_no_irq, dsc_endian;
    logic [2:0]  dsc_swap;
    logic        eng_done = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    sg_desc_queue u_sg_desc_queue (
        .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .dsc_valid(dsc_valid), .dsc_ready(dsc_ready), .dsc_addr(dsc_addr),
        .dsc_len(dsc_len), .dsc_to_card(dsc_to_card), .dsc_no_irq(dsc_no_irq),
        .dsc_swap(dsc_swap), .dsc_endian(dsc_endian), .eng_done(eng_done),
        .irq(irq)
    );

    typedef struct { logic [63:0] a; logic [63:0] c; } ent_t;
    ent_t        mq[$];
    logic        m_clr = 1'b1, m_inf = 1'b0, m_irq = 1'b0, m_ovf = 1'b0;
    logic [4:0]  m_thr = '0;
    logic [63:0] m_stage = '0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_rd(input logic [7:0] a);
        logic [63:0] r = '0;
        int n = mq.size();
        case (a)
            8'h00: begin r[16] = m_clr; r[12:8] = m_thr; r[4:0] = 5'(n); end
            8'h10: r = m_stage;
            8'h20: begin r[0] = m_irq; r[1] = m_ovf; r[2] = (n != 0) && (n <= int'(m_thr)); end
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic logic exp_valid();
        return !m_clr && mq.size() > 0 && !m_inf;
    endfunction

    // Reference model step on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete(); m_clr = 1'b1; m_thr = '0; m_stage = '0;
            m_inf = 1'b0; m_irq = 1'b0; m_ovf = 1'b0;
        end else begin
            bit acc, pop, flush, iset, oset, wcfg, wcmd;
            int old_n;
            old_n = mq.size();
            acc   = exp_valid() && dsc_ready;
            pop   = m_inf && eng_done;
            wcfg  = reg_wen && reg_addr == 8'h00;
            wcmd  = reg_wen && reg_addr == 8'h18;
            flush = m_clr || (wcfg && reg_wdata[16]);
            iset = 0; oset = 0;
            if (flush) begin
                mq.delete(); m_inf = 1'b0;
            end else if (pop) begin
                if (!mq[0].c[60]) iset = 1;
                void'(mq.pop_front());
                m_inf = 1'b0;
            end else if (acc) m_inf = 1'b1;
            if (wcmd) begin
                if (m_clr || old_n == 16) oset = 1;
                else mq.push_back('{a: m_stage, c: reg_wdata});
            end
            if (reg_wen && reg_addr == 8'h20) begin
                if (reg_wdata[0]) m_irq = 1'b0;
                if (reg_wdata[1]) m_ovf = 1'b0;
            end
            if (iset) m_irq = 1'b1;
            if (oset) m_ovf = 1'b1;
            if (reg_wen && reg_addr == 8'h10) m_stage = reg_wdata & ~64'h7;
            if (wcfg) begin m_clr = reg_wdata[16]; m_thr = reg_wdata[12:8]; end
        end
    end

    // Compare every output against the model shortly after each edge.
    always @(posedge clk) begin
        #1;
        chk("R7 dsc_valid per-cycle", 64'(dsc_valid), 64'(exp_valid()));
        chk("R9 irq per-cycle", 64'(irq), 64'(m_irq));
        chk("R2/R4/R10 reg_rdata per-cycle", reg_rdata, exp_rd(reg_raddr));
        if (exp_valid()) begin
            chk("R3 dsc_addr per-cycle", dsc_addr, mq[0].a);
            chk("R5 dsc_len per-cycle", 64'(dsc_len), 64'(mq[0].c[55:36]));
            chk("R5 flags per-cycle", {58'b0, dsc_to_card, dsc_no_irq, dsc_swap, dsc_endian},
                {58'b0, mq[0].c[62], mq[0].c[60], mq[0].c[59:57], mq[0].c[56]});
        end
    end

    task automatic wr(input logic [7:0] a, input logic [63:0] d);
        @(negedge clk);
        reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wen = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [63:0] d);
        @(negedge clk);
        reg_raddr = a;
        @(posedge clk); #1;
        d = reg_rdata;
    endtask

    task automatic pulse_ready();
        @(negedge clk); dsc_ready = 1'b1;
        @(negedge clk); dsc_ready = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk); eng_done = 1'b1;
        @(negedge clk); eng_done = 1'b0;
    endtask

    function automatic logic [63:0] cmd(input bit dir, input bit nirq, input logic [2:0] sw,
                                        input bit en, input logic [19:0] len);
        logic [63:0] c = '0;
        c[62] = dir; c[60] = nirq; c[59:57] = sw; c[56] = en; c[55:36] = len;
        return c;
    endfunction

    initial begin
        logic [63:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rd(8'h00, v); chk("R1 cfg after reset", v, 64'h10000);
        rd(8'h20, v); chk("R1 status after reset", v, 64'h0);
        chk("R1 valid/irq after reset", {62'b0, dsc_valid, irq}, 64'h0);

        wr(8'h18, cmd(0, 0, 3'b0, 0, 20'h1));
        rd(8'h20, v); chk("R6 push while disabled sets overflow", v, 64'h2);
        rd(8'h00, v); chk("R6 push while disabled keeps count", v, 64'h10000);
        wr(8'h20, 64'h2);
        rd(8'h20, v); chk("R12 overflow cleared", v, 64'h0);

        wr(8'h00, 64'h300);
        rd(8'h00, v); chk("R2 enable and threshold", v, 64'h300);
        wr(8'h10, 64'h1007);
        rd(8'h10, v); chk("R3 staged address low bits dropped", v, 64'h1000);
        wr(8'h18, cmd(1, 1, 3'b101, 1, 20'h7));
        wr(8'h10, 64'h2000);
        wr(8'h18, cmd(0, 0, 3'b000, 0, 20'hFFFFF));
        rd(8'h00, v); chk("R4 count after two pushes", v, 64'h302);
        rd(8'h20, v); chk("R10 low water at count 2 thr 3", v, 64'h4);
        chk("R3 head address", dsc_addr, 64'h1000);
        chk("R5 head fields", {44'b0, dsc_len}, 64'h7);
        chk("R5 head flags", {58'b0, dsc_to_card, dsc_no_irq, dsc_swap, dsc_endian}, 64'h3B);

        pulse_done();
        rd(8'h00, v); chk("R8 stray done ignored", v, 64'h302);
        pulse_ready();
        @(posedge clk); #1;
        chk("R7 valid low while accepted", 64'(dsc_valid), 64'h0);
        pulse_done();
        rd(8'h00, v); chk("R8 done removes head", v, 64'h301);
        chk("R9 suppressed entry leaves irq low", 64'(irq), 64'h0);
        chk("R7 second entry in order", dsc_addr, 64'h2000);
        pulse_ready(); pulse_done();
        rd(8'h20, v); chk("R9 irq set by unsuppressed entry", v, 64'h1);
        wr(8'h20, 64'h0);
        rd(8'h20, v); chk("R9 writing 0 keeps irq", v, 64'h1);
        wr(8'h20, 64'h1);
        rd(8'h20, v); chk("R9 writing 1 clears irq", v, 64'h0);

        for (int i = 0; i < 16; i++) begin
            wr(8'h10, 64'(i) << 8);
            wr(8'h18, cmd(0, 1, 3'b0, 0, 20'(i)));
        end
        rd(8'h00, v); chk("R4 count reaches 16", v, 64'h310);
        wr(8'h18, cmd(0, 1, 3'b0, 0, 20'h1));
        rd(8'h00, v); chk("R6 push when full dropped", v, 64'h310);
        rd(8'h20, v); chk("R6 overflow on full", v, 64'h2);
        pulse_ready(); pulse_done();
        pulse_ready();
        @(negedge clk);
        eng_done = 1'b1; reg_wen = 1'b1; reg_addr = 8'h18; reg_wdata = cmd(0, 1, 3'b0, 0, 20'h2);
        @(negedge clk);
        eng_done = 1'b0; reg_wen = 1'b0;
        rd(8'h00, v); chk("R11 push and removal together", v, 64'h30F);

        wr(8'h00, 64'h10000);
        rd(8'h00, v); chk("R2 clear flushes", v, 64'h10000);
        chk("R2 valid low when cleared", 64'(dsc_valid), 64'h0);
        wr(8'h20, 64'h3);
        wr(8'h00, 64'h300);

        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            reg_wen   = ($urandom % 3) == 0;
            case ($urandom % 5)
                0: reg_addr = 8'h00;
                1: reg_addr = 8'h10;
                2: reg_addr = 8'h18;
                3: reg_addr = 8'h20;
                default: reg_addr = 8'h08;
            endcase
            reg_wdata = {$urandom, $urandom};
            if (reg_addr == 8'h00) reg_wdata[16] = (($urandom % 8) == 0);
            case ($urandom % 4)
                0: reg_raddr = 8'h00;
                1: reg_raddr = 8'h10;
                2: reg_raddr = 8'h20;
                default: reg_raddr = 8'h18;
            endcase
            dsc_ready = $urandom % 2;
            eng_done  = ($urandom % 3) == 0;
        end
        @(negedge clk);
        reg_wen = 1'b0; dsc_ready = 1'b0; eng_done = 1'b0;
        repeat (2) @(negedge clk);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule